// File: doc/BRIEF.md
# Calendar Clock Register Core

This block is a battery-style real-time clock core with a byte-wide register bus. Seven BCD counters hold seconds, minutes, hours, weekday, day of month, month and two-digit year. They advance on a single-cycle 1 Hz enable pulse, and the day and month counters follow month lengths and leap years. Software never reads the live counters. A rising edge of the snapshot bit copies them into a set of user image registers, and reads of the time addresses return those registers. To set the time, software raises the freeze bit, writes the image registers, and then drops the freeze bit. The counters take the image on that release.

A small sequencer controls the freeze-and-load cycle. Its states are `ST_RUN` (counting), `ST_FROZEN` (counting stopped) and `ST_LOAD` (a one-cycle copy of the image into the counters). Its transitions are RUN→FROZEN when the freeze bit is set, FROZEN→LOAD when the freeze bit is cleared, LOAD→RUN, and LOAD→FROZEN when the freeze bit is set again during the load cycle. A sticky century flag records each year wrap and clears when software reads it. A halt bit stops the time base. A mode bit chooses whether the auxiliary output carries the calibration waveform or the power-fail comparator input.

Top module: `rtc_regfile_core`

Register map:

| Address | Contents |
|---|---|
| 0x0 (control) | bit6 century flag (read-only), bit2 calibration-output mode, bit1 freeze, bit0 snapshot |
| 0x1 (trim) | bit7 halt, bit5 trim sign, bits4:0 trim magnitude |
| 0x2 to 0x8 | image registers: seconds, minutes, hours, weekday, date, month, year |

## Requirements
- R1: After reset, control reads 0x00. Trim reads 0x80 when `batt_absent` was high during reset and 0x00 otherwise. The image reads 00:00:00, weekday 01, date 01/01/00.
- R2: While the halt bit (0x1 bit7) is 1, tick pulses do not change the counters.
- R3: Seconds and minutes count BCD 00–59 and hours count 00–23, with a carry into the next field on each wrap.
- R4: Weekday counts 1–7. Date wraps to 01 after 30 in months 04, 06, 09 and 11, after 28 in month 02 (29 when the year is a multiple of 4, including 00), and after 31 otherwise. Month wraps 12→01 and year wraps 99→00.
- R5: Writing 1 to control bit0 while it reads 0 copies the counters into the image. Writing 1 again while it is already 1 does not refresh the image.
- R6: While control bit1 is 1, ticks are ignored and the counters keep their value. After bit1 returns to 0, the counters take the image contents and counting resumes.
- R7: A year wrap 99→00 sets control bit6. A read of address 0x0 clears it, and writes to address 0x0 never change it.
- R8: If a year wrap and a read of address 0x0 occur in the same cycle, the flag ends up set and that read returns the old value.
- R9: `aux_out` equals `cal_wave` while control bit2 is 1, and equals `pwr_fail_in` while it is 0.
- R10: Reserved bits (control bits 7, 5:3 and trim bit 6) read 0 whatever is written. The trim sign and magnitude read back as written.
- R11: `rdata` is registered. It shows the addressed register one clock after `rd_en` is sampled and holds its value when `rd_en` is low. Addresses 0x9 and above read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous-free reset (sampled on clk) |
| batt_absent | input | 1 | High during reset when no backup supply is present; forces halt |
| tick_1hz | input | 1 | Single-cycle one-second enable |
| cal_wave | input | 1 | Calibration waveform routed to `aux_out` in calibration mode |
| pwr_fail_in | input | 1 | Power-fail comparator result routed to `aux_out` otherwise |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Registered read data |
| aux_out | output | 1 | Calibration or power-fail output |

## Verification
The hardest case to reach from the ports is a year wrap that lands in the same clock as a read of the control register. The live counters cannot be written directly. The bench therefore freezes the sequencer, writes 99-12-31 23:59:59 into the image, releases the freeze, and waits for the load cycle to finish. It then raises the tick and the control-register read strobe on the same clock edge. The read must return the old flag value, the next read must show the flag set, and a later read must show it cleared. The calendar corners use the same freeze-and-load path to preset the time one tick before each boundary, and the snapshot path to read the result.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] minute;
        logic [7:0] sec;
    } rtc_time_t;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_FROZEN = 2'd1,
        ST_LOAD   = 2'd2
    } rtc_seq_e;

    localparam int REG_CTRL = 0;
    localparam int REG_TRIM = 1;
    localparam int REG_SEC  = 2;
    localparam int REG_MIN  = 3;
    localparam int REG_HR   = 4;
    localparam int REG_DOW  = 5;
    localparam int REG_DATE = 6;
    localparam int REG_MON  = 7;
    localparam int REG_YR   = 8;

    localparam rtc_time_t TIME_INIT = '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                                        hr: 8'h00, minute: 8'h00, sec: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        return (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : {v[7:4], v[3:0] + 4'h1};
    endfunction

    // Two-digit BCD year divisible by four: even tens need 0/4/8, odd tens need 2/6.
    function automatic logic leap_year(input logic [7:0] y);
        if (y[4])
            return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
        return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now,
    output logic      year_wrap
);

    logic      sec_end, min_end, hr_end, day_end, mon_end;
    rtc_time_t nxt;

    always_comb begin
        sec_end = (now.sec == 8'h59);
        min_end = (now.minute == 8'h59);
        hr_end  = (now.hr == 8'h23);
        day_end = (now.date == month_last(now.mon, now.yr));
        mon_end = (now.mon == 8'h12);

        nxt     = now;
        nxt.sec = sec_end ? 8'h00 : bcd_inc(now.sec);
        if (sec_end) begin
            nxt.minute = min_end ? 8'h00 : bcd_inc(now.minute);
            if (min_end) begin
                nxt.hr = hr_end ? 8'h00 : bcd_inc(now.hr);
                if (hr_end) begin
                    nxt.dow  = (now.dow == 8'h07) ? 8'h01 : bcd_inc(now.dow);
                    nxt.date = day_end ? 8'h01 : bcd_inc(now.date);
                    if (day_end) begin
                        nxt.mon = mon_end ? 8'h01 : bcd_inc(now.mon);
                        if (mon_end)
                            nxt.yr = (now.yr == 8'h99) ? 8'h00 : bcd_inc(now.yr);
                    end
                end
            end
        end

        year_wrap = step && sec_end && min_end && hr_end && day_end && mon_end
                    && (now.yr == 8'h99);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            now <= TIME_INIT;
        else if (load)
            now <= load_val;
        else if (step)
            now <= nxt;
    end

endmodule

// File: rtl/rtc_wr_seq.sv
module rtc_wr_seq
    import rtc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hold_req,
    output logic     count_en,
    output logic     load_pulse,
    output rtc_seq_e state
);

    rtc_seq_e nxt_state;

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_RUN:    if (hold_req)  nxt_state = ST_FROZEN;
            ST_FROZEN: if (!hold_req) nxt_state = ST_LOAD;
            ST_LOAD:   nxt_state = hold_req ? ST_FROZEN : ST_RUN;
            default:   nxt_state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_RUN;
        else
            state <= nxt_state;
    end

    always_comb begin
        count_en   = 1'b0;
        load_pulse = 1'b0;
        unique case (state)
            ST_RUN:    count_en   = !hold_req;
            ST_FROZEN: count_en   = 1'b0;
            ST_LOAD:   load_pulse = 1'b1;
            default:   count_en   = 1'b0;
        endcase
    end

endmodule

// File: rtl/rtc_regfile_core.sv
module rtc_regfile_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              batt_absent,
    input  logic              tick_1hz,
    input  logic              cal_wave,
    input  logic              pwr_fail_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    output logic              aux_out
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_TRIM = ADDR_W'(REG_TRIM);

    logic       cent_flag, cal_mode, hold_bit, snap_bit;
    logic       osc_halt, trim_sign;
    logic [4:0] trim_mag;
    rtc_time_t  image, now_time;
    logic       count_en, cal_load, step, yr_wrap, capture;
    rtc_seq_e   seq_state;
    logic [7:0] rd_mux;

    rtc_wr_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_req   (hold_bit),
        .count_en   (count_en),
        .load_pulse (cal_load),
        .state      (seq_state)
    );

    assign step = tick_1hz && !osc_halt && count_en;

    rtc_calendar u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .load      (cal_load),
        .load_val  (image),
        .now       (now_time),
        .year_wrap (yr_wrap)
    );

    assign capture = wr_en && (addr == A_CTRL) && wdata[0] && !snap_bit;
    assign aux_out = cal_mode ? cal_wave : pwr_fail_in;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cent_flag <= 1'b0;
            cal_mode  <= 1'b0;
            hold_bit  <= 1'b0;
            snap_bit  <= 1'b0;
            osc_halt  <= batt_absent;
            trim_sign <= 1'b0;
            trim_mag  <= '0;
            image     <= TIME_INIT;
        end else begin
            if (wr_en && addr == A_CTRL)
                {cal_mode, hold_bit, snap_bit} <= wdata[2:0];
            if (wr_en && addr == A_TRIM) begin
                osc_halt  <= wdata[7];
                trim_sign <= wdata[5];
                trim_mag  <= wdata[4:0];
            end
            if (yr_wrap)
                cent_flag <= 1'b1;
            else if (rd_en && addr == A_CTRL)
                cent_flag <= 1'b0;
            if (capture)
                image <= now_time;
            else if (wr_en) begin
                case (addr)
                    ADDR_W'(REG_SEC):  image.sec    <= wdata;
                    ADDR_W'(REG_MIN):  image.minute <= wdata;
                    ADDR_W'(REG_HR):   image.hr     <= wdata;
                    ADDR_W'(REG_DOW):  image.dow    <= wdata;
                    ADDR_W'(REG_DATE): image.date   <= wdata;
                    ADDR_W'(REG_MON):  image.mon    <= wdata;
                    ADDR_W'(REG_YR):   image.yr     <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            ADDR_W'(REG_CTRL): rd_mux = {1'b0, cent_flag, 3'b000, cal_mode, hold_bit, snap_bit};
            ADDR_W'(REG_TRIM): rd_mux = {osc_halt, 1'b0, trim_sign, trim_mag};
            ADDR_W'(REG_SEC):  rd_mux = image.sec;
            ADDR_W'(REG_MIN):  rd_mux = image.minute;
            ADDR_W'(REG_HR):   rd_mux = image.hr;
            ADDR_W'(REG_DOW):  rd_mux = image.dow;
            ADDR_W'(REG_DATE): rd_mux = image.date;
            ADDR_W'(REG_MON):  rd_mux = image.mon;
            ADDR_W'(REG_YR):   rd_mux = image.yr;
            default:           rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= 8'h00;
        else if (rd_en)
            rdata <= rd_mux;
    end

endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              osc_halt,
    input logic              hold_bit,
    input logic              snap_bit,
    input logic              cal_load,
    input logic              yr_wrap,
    input logic              cent_flag,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata,
    input logic [55:0]       now_time,
    input logic [55:0]       image
);

    logic time_wr;
    assign time_wr = wr_en && (addr >= ADDR_W'(2)) && (addr <= ADDR_W'(8));

    a_r2_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_halt && !cal_load) |=> $stable(now_time));

    a_r6_freeze_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_bit && !cal_load) |=> $stable(now_time));

    a_r6_load_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_bit) |=> cal_load);

    a_r5_no_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_bit && !time_wr) |=> $stable(image));

    a_r7_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        yr_wrap |=> cent_flag);

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == '0 && !yr_wrap) |=> !cent_flag);

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == '0) |=> (rdata[7] == 1'b0 && rdata[5:3] == 3'b000));

endmodule

bind rtc_regfile_core rtc_core_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_halt  (osc_halt),
    .hold_bit  (hold_bit),
    .snap_bit  (snap_bit),
    .cal_load  (cal_load),
    .yr_wrap   (yr_wrap),
    .cent_flag (cent_flag),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .rdata     (rdata),
    .now_time  (now_time),
    .image     (image)
);

// File: tb/tb_rtc_regfile_core.sv
module tb_rtc_regfile_core;

    logic       clk = 1'b0;
    logic       rst_n, batt_absent, tick_1hz, cal_wave, pwr_fail_in;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic       wr_en, rd_en;
    logic [7:0] rdata;
    logic       aux_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rtc_regfile_core #(.ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .batt_absent(batt_absent), .tick_1hz(tick_1hz),
        .cal_wave(cal_wave), .pwr_fail_in(pwr_fail_in), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .aux_out(aux_out)
    );

    // {yr, mon, date, dow, hr, min, sec}: preset one tick before, expected after one tick
    localparam logic [55:0] VEC_IN [10] = '{
        56'h00_01_01_01_00_00_00, 56'h23_06_15_03_12_59_59, 56'h23_01_31_07_23_59_59,
        56'h23_02_28_02_23_59_59, 56'h24_02_28_02_23_59_59, 56'h23_04_30_04_23_59_59,
        56'h99_12_31_05_23_59_59, 56'h00_02_28_01_23_59_59, 56'h10_09_30_06_19_59_59,
        56'h24_02_29_03_23_59_59};
    localparam logic [55:0] VEC_OUT [10] = '{
        56'h00_01_01_01_00_00_01, 56'h23_06_15_03_13_00_00, 56'h23_02_01_01_00_00_00,
        56'h23_03_01_03_00_00_00, 56'h24_02_29_03_00_00_00, 56'h23_05_01_05_00_00_00,
        56'h00_01_01_06_00_00_00, 56'h00_02_29_02_00_00_00, 56'h10_09_30_06_20_00_00,
        56'h24_03_01_04_00_00_00};
    localparam logic [9:0] VEC_WRAP = 10'b00_0100_0000;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic preset(input logic [55:0] t);
        wr(4'h0, 8'h02);
        for (int a = 2; a <= 8; a++) wr(4'(a), t[(a-2)*8 +: 8]);
        wr(4'h0, 8'h00);
        idle(3);
    endtask

    task automatic snap();
        wr(4'h0, 8'h01);
        wr(4'h0, 8'h00);
    endtask

    task automatic do_reset(input logic batt);
        @(negedge clk); rst_n = 1'b0; batt_absent = batt;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        tick_1hz = 0; cal_wave = 0; pwr_fail_in = 0; addr = 0; wdata = 0;
        wr_en = 0; rd_en = 0; rst_n = 0; batt_absent = 0;
        do_reset(1'b0);

        // R1 reset state
        rd(4'h0, v); check("R1 ctrl", v, 8'h00);
        rd(4'h1, v); check("R1 trim", v, 8'h00);
        rd(4'h2, v); check("R1 sec", v, 8'h00);
        rd(4'h5, v); check("R1 dow", v, 8'h01);
        rd(4'h6, v); check("R1 date", v, 8'h01);
        rd(4'h7, v); check("R1 mon", v, 8'h01);
        rd(4'h8, v); check("R1 yr", v, 8'h00);

        // R3 / R4 table walk, with R7 flag after each step
        for (int i = 0; i < 10; i++) begin
            preset(VEC_IN[i]);
            tick();
            snap();
            for (int a = 2; a <= 8; a++) begin
                rd(4'(a), v);
                check("R3/R4 calendar", v, VEC_OUT[i][(a-2)*8 +: 8]);
            end
            rd(4'h0, v);
            check("R7 century flag", v, VEC_WRAP[i] ? 8'h40 : 8'h00);
        end

        // R5 snapshot only on rising edge of bit0
        wr(4'h0, 8'h01);
        tick();
        wr(4'h0, 8'h01);
        rd(4'h2, v); check("R5 no refresh while held", v, 8'h00);
        wr(4'h0, 8'h00);
        wr(4'h0, 8'h01);
        rd(4'h2, v); check("R5 fresh capture", v, 8'h01);
        wr(4'h0, 8'h00);

        // R6 ticks ignored while frozen, image loaded on release
        wr(4'h0, 8'h02);
        wr(4'h2, 8'h30);
        tick(); tick();
        wr(4'h0, 8'h00);
        idle(3);
        tick();
        snap();
        rd(4'h2, v); check("R6 load and resume sec", v, 8'h31);
        rd(4'h3, v); check("R6 load min", v, 8'h00);

        // R2 halt
        wr(4'h1, 8'h80);
        tick(); tick(); tick();
        snap();
        rd(4'h2, v); check("R2 halted", v, 8'h31);
        wr(4'h1, 8'h00);
        tick();
        snap();
        rd(4'h2, v); check("R2 resumed", v, 8'h32);

        // R10 reserved bits and trim storage
        wr(4'h1, 8'hFF);
        rd(4'h1, v); check("R10 trim readback", v, 8'hBF);
        wr(4'h1, 8'h00);
        wr(4'h0, 8'hF8);
        rd(4'h0, v); check("R10 ctrl reserved", v, 8'h00);

        // R9 output select
        wr(4'h0, 8'h04);
        rd(4'h0, v); check("R9 mode bit", v, 8'h04);
        @(negedge clk); cal_wave = 1; pwr_fail_in = 0; #1;
        check("R9 cal mode high", {7'd0, aux_out}, 8'h01);
        @(negedge clk); cal_wave = 0; pwr_fail_in = 1; #1;
        check("R9 cal mode low", {7'd0, aux_out}, 8'h00);
        wr(4'h0, 8'h00);
        #1; check("R9 pfail mode high", {7'd0, aux_out}, 8'h01);
        @(negedge clk); pwr_fail_in = 0; cal_wave = 1; #1;
        check("R9 pfail mode low", {7'd0, aux_out}, 8'h00);
        cal_wave = 0;

        // R8 wrap and flag read in the same cycle
        preset(56'h99_12_31_05_23_59_59);
        @(negedge clk); tick_1hz = 1; addr = 4'h0; rd_en = 1;
        @(negedge clk); tick_1hz = 0; rd_en = 0;
        check("R8 same-cycle read old", rdata, 8'h00);
        wr(4'h0, 8'h00);
        rd(4'h0, v); check("R8 set wins / R7 write ignored", v, 8'h40);
        rd(4'h0, v); check("R7 cleared by read", v, 8'h00);

        // R11 latency and unmapped
        wr(4'h1, 8'h25);
        @(negedge clk); addr = 4'h1; rd_en = 1; #1;
        check("R11 not combinational", rdata, 8'h00);
        @(negedge clk); rd_en = 0;
        check("R11 one-cycle latency", rdata, 8'h25);
        @(negedge clk); addr = 4'h0;
        check("R11 hold when idle", rdata, 8'h25);
        rd(4'hF, v); check("R11 unmapped", v, 8'h00);

        // R1 / R2 reset with no backup supply forces halt
        do_reset(1'b1);
        rd(4'h1, v); check("R1 halt after cold reset", v, 8'h80);
        tick();
        snap();
        rd(4'h2, v); check("R2 cold halt no count", v, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule